// File: doc/BRIEF.md
# Manchester Line Encoder with Sync Preamble

The block turns a serial NRZ stream into a pair of complementary Manchester II line outputs. One oversampling system clock drives everything. A free-running divider inside the block splits that clock into bit periods of 16 or 32 system clocks, as the rate-select input chooses. Each bit period has two half-bit cells. A 1X bit clock output is high during the first cell and low during the second. External logic uses this clock to present NRZ data, and the block samples that data on the bit clock's falling edge.

Clear-to-send gates the block. While it is high, the line is idle: both outputs are high and the bit clock is low. When it drops, the block waits for the next bit boundary. It then sends a fixed preamble of eight zero bits, followed by a three-bit command sync that breaks the Manchester rule: three half-cells high, then three half-cells low. After the sync, data bits go out back to back, with no parity or framing, until clear-to-send rises again. Data bits leave on the line in inverted polarity.

Top module: `mench_encoder`

## Requirements
- R1: While rst_ni is low, tx_p_o and tx_n_o are both 1 and bclk_o is 0, and the preamble position returns to its start.
- R2: If cts_i is high at a clock edge, then after that edge tx_p_o = tx_n_o = 1 and bclk_o = 0. This holds in every phase of a transmission, including the preamble, and the transmission is abandoned.
- R3: A bit period lasts 16 clocks when speed_i = 0 and 32 clocks when speed_i = 1. While transmitting, bclk_o is 1 for the first half of each period and 0 for the second half.
- R4: While transmitting, tx_n_o is the complement of tx_p_o.
- R5: Bit boundaries fall on clock edges numbered N, 2N, 3N and so on, counted from the first edge after rst_ni rises (N is the period). Transmission starts with the first boundary edge at which cts_i is low while the line is idle. Until then the line stays idle.
- R6: The first 8 bit periods carry zero bits. In each of them tx_p_o is 1 in the first half and 0 in the second, whatever nrz_i does.
- R7: The next 3 bit periods carry the sync. tx_p_o is 1 for the first three half-cells and 0 for the last three.
- R8: nrz_i is sampled at the clock edge that ends the first half of each bit period. A sampled bit d goes out in the following period, with tx_p_o = ~d in the first half and d in the second half. The bit sampled in the last sync period is the first data bit.
- R9: Data bits follow one another with no gap for as long as cts_i stays low. A later high-to-low cycle of cts_i starts a fresh preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 1 | Rate select: 0 gives 16 clocks per bit, 1 gives 32 |
| cts_i | input | 1 | Clear-to-send: high keeps the line idle, low allows transmission |
| nrz_i | input | 1 | Serial NRZ data to encode |
| bclk_o | output | 1 | 1X bit clock, high in the first half of each bit while transmitting |
| tx_p_o | output | 1 | Manchester line output, inverted polarity, idle high |
| tx_n_o | output | 1 | Complement of tx_p_o while transmitting, idle high |

## Verification
All outputs come straight from state flops, so every result is due one edge after its cause. Idle follows one edge after cts_i is seen high. The first preamble cell appears right after boundary edge s. The line level in cycle t = e - s after edge e is fixed by bit index t/N and half t mod N. A bit sampled at edge s + bN + N/2 appears in period b+1. The bench keeps its own count of edges since reset release, derives s from that count, drives nrz_i for period b during that same period, and compares all three outputs at every falling clock edge over every start phase at both rates.

// File: rtl/mench_pkg.sv
package mench_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2,
    ST_DATA = 2'd3
  } enc_state_e;

  // sync spans three bit periods, split into 3 high and 3 low half cells
  localparam int unsigned SYNC_BITS = 3;
endpackage

// File: rtl/mench_timebase.sv
module mench_timebase #(
  parameter int unsigned FAST_DIV = 16,
  parameter int unsigned SLOW_DIV = 32,
  localparam int unsigned CW = $clog2(SLOW_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic bit_end_o,
  output logic mid_o,
  output logic late_o
);
  localparam logic [CW-1:0] LIM_F = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] LIM_S = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, lim;

  assign lim = slow_i ? LIM_S : LIM_F;

  // free-running; >= covers a rate change in the middle of a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign bit_end_o = (cnt_q >= lim);
  assign mid_o     = (cnt_q == (lim >> 1));
  assign late_o    = (cnt_q > (lim >> 1));
endmodule

// File: rtl/mench_sequencer.sv
module mench_sequencer
  import mench_pkg::*;
#(
  parameter int unsigned PRE_BITS = 8,
  localparam int unsigned MAXB = (PRE_BITS > SYNC_BITS) ? PRE_BITS : SYNC_BITS,
  localparam int unsigned IW = $clog2(MAXB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cts_i,
  input  logic          bit_end_i,
  output enc_state_e    state_o,
  output logic [IW-1:0] idx_o
);
  enc_state_e    state_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (cts_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (bit_end_i) begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_PRE;
          idx_q   <= '0;
        end
        ST_PRE: begin
          if (idx_q == IW'(PRE_BITS - 1)) begin
            state_q <= ST_SYNC;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (idx_q == IW'(SYNC_BITS - 1)) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_DATA;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/mench_shaper.sv
module mench_shaper
  import mench_pkg::*;
#(
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nrz_i,
  input  logic          mid_i,
  input  logic          bit_end_i,
  input  logic          late_i,
  input  enc_state_e    state_i,
  input  logic [IW-1:0] idx_i,
  output logic          tx_p_o,
  output logic          tx_n_o,
  output logic          bclk_o
);
  logic smp_q, cur_q;
  logic lvl, active;

  // sample at the bit clock fall, send during the next period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0;
      cur_q <= 1'b0;
    end else begin
      if (mid_i)     smp_q <= nrz_i;
      if (bit_end_i) cur_q <= smp_q;
    end
  end

  always_comb begin
    lvl    = 1'b1;
    active = 1'b1;
    unique case (state_i)
      ST_IDLE: active = 1'b0;
      ST_PRE:  lvl = !late_i;
      ST_SYNC: lvl = ({idx_i, late_i} < (IW+1)'(SYNC_BITS));
      ST_DATA: lvl = late_i ? cur_q : !cur_q;
      default: active = 1'b0;
    endcase
  end

  assign tx_p_o = lvl;
  assign tx_n_o = active ? !lvl : 1'b1;
  assign bclk_o = active & !late_i;
endmodule

// File: rtl/mench_encoder.sv
module mench_encoder
  import mench_pkg::*;
#(
  parameter int unsigned FAST_DIV = 16,
  parameter int unsigned SLOW_DIV = 32,
  parameter int unsigned PRE_BITS = 8,
  localparam int unsigned MAXB = (PRE_BITS > SYNC_BITS) ? PRE_BITS : SYNC_BITS,
  localparam int unsigned IW = $clog2(MAXB)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_i,
  input  logic cts_i,
  input  logic nrz_i,
  output logic bclk_o,
  output logic tx_p_o,
  output logic tx_n_o
);
  logic          bit_end, mid, late;
  enc_state_e    state;
  logic [IW-1:0] idx;

  mench_timebase #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slow_i   (speed_i),
    .bit_end_o(bit_end),
    .mid_o    (mid),
    .late_o   (late)
  );

  mench_sequencer #(
    .PRE_BITS(PRE_BITS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .bit_end_i(bit_end),
    .state_o  (state),
    .idx_o    (idx)
  );

  mench_shaper #(
    .IW(IW)
  ) u_shp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nrz_i    (nrz_i),
    .mid_i    (mid),
    .bit_end_i(bit_end),
    .late_i   (late),
    .state_i  (state),
    .idx_i    (idx),
    .tx_p_o   (tx_p_o),
    .tx_n_o   (tx_n_o),
    .bclk_o   (bclk_o)
  );
endmodule

// File: rtl/mench_encoder_chk.sv
module mench_encoder_chk #(
  parameter int unsigned SLOW_DIV = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cts_i,
  input logic bclk_o,
  input logic tx_p_o,
  input logic tx_n_o
);
  logic [7:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_run_q <= '0;
    else if (!bclk_o) hi_run_q <= '0;
    else if (hi_run_q != 8'hff) hi_run_q <= hi_run_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (tx_p_o && tx_n_o && !bclk_o);
    end
  end

  p_cts_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_i |=> (tx_p_o && tx_n_o && !bclk_o));

  p_bclk_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= 8'(SLOW_DIV / 2));

  p_complement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_p_o == tx_n_o) |-> (tx_p_o && !bclk_o));

  p_edge_on_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tx_p_o) && !(tx_p_o && tx_n_o)) |-> !$stable(bclk_o));
endmodule

bind mench_encoder mench_encoder_chk #(.SLOW_DIV(SLOW_DIV)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cts_i (cts_i),
  .bclk_o(bclk_o),
  .tx_p_o(tx_p_o),
  .tx_n_o(tx_n_o)
);

// File: tb/tb_mench_encoder.sv
`timescale 1ns/1ps
module tb_mench_encoder;
  logic clk_i = 1'b0;
  logic rst_ni, speed_i, cts_i, nrz_i;
  logic bclk_o, tx_p_o, tx_n_o;
  int   e;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #10 clk_i = ~clk_i;

  // edges since reset release
  always @(posedge clk_i) begin
    if (!rst_ni) e <= 0;
    else e <= e + 1;
  end

  mench_encoder dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .speed_i(speed_i),
    .cts_i  (cts_i),
    .nrz_i  (nrz_i),
    .bclk_o (bclk_o),
    .tx_p_o (tx_p_o),
    .tx_n_o (tx_n_o)
  );

  task automatic chk(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (edge %0d)", rq, act, exp, e);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(rq, tx_p_o, 1'b1);
    chk(rq, tx_n_o, 1'b1);
    chk(rq, bclk_o, 1'b0);
  endtask

  function automatic logic dbit(input int k, input int seed);
    return logic'(((k * 13 + seed * 7 + 3) % 5) < 2);
  endfunction

  // entered at a falling edge with cts_i high
  task automatic burst(input int n, input int lead, input int cut_t,
                       input int seed, input bit again);
    int s, t, b, c;
    logic h, ex;
    string tag;
    repeat (lead) begin
      @(negedge clk_i);
      chk_idle("R2");
    end
    cts_i = 1'b0;
    s = (e / n + 1) * n;
    while (e < s + cut_t) begin
      t = e - s;
      if (t >= 0 && t / n >= 10) nrz_i = dbit(t / n - 10, seed);
      else nrz_i = logic'(e[1]);
      @(negedge clk_i);
      t = e - s;
      if (t < 0) begin
        chk_idle("R5");
      end else begin
        b = t / n;
        h = logic'((t % n) >= n / 2);
        if (b < 8) begin
          ex = !h; tag = "R6";
        end else if (b < 11) begin
          c = (b - 8) * 2 + int'(h);
          ex = logic'(c < 3); tag = "R7";
        end else begin
          ex = h ? dbit(b - 11, seed) : !dbit(b - 11, seed);
          tag = (b >= 19) ? "R9" : "R8";
        end
        if (t == 0) chk(again ? "R9" : "R5", tx_p_o, 1'b1);
        chk(tag, tx_p_o, ex);
        chk("R4", tx_n_o, !ex);
        chk("R3", bclk_o, !h);
      end
    end
    cts_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk_idle("R2");
    end
  endtask

  initial begin
    rst_ni  = 1'b0;
    cts_i   = 1'b1;
    nrz_i   = 1'b0;
    speed_i = 1'b0;
    for (int spd = 0; spd < 2; spd++) begin
      for (int off = 0; off < (spd != 0 ? 32 : 16); off++) begin
        int n;
        n = (spd != 0) ? 32 : 16;
        rst_ni  = 1'b0;
        cts_i   = 1'b1;
        speed_i = logic'(spd);
        repeat (2) @(negedge clk_i);
        chk_idle("R1");
        rst_ni = 1'b1;
        burst(n, off, 17 * n - 3, off, 1'b0);
        burst(n, 2 + off % 3, 21 * n - 3, off + 1, 1'b1);
        burst(n, 1, 3 * n + 5, off + 2, 1'b1);
        nrz_i = 1'b1;
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk_idle("R1");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule